// File: doc/BRIEF.md
# Wave Issue Arbiter with Stall Sampling

This block models the issue stage of one SIMD. A set of waves competes for eight execution pipes. Every cycle, each wave presents an active flag, a set of blocking-condition flags and a 3-bit target pipe. For each pipe the block picks at most one ready wave. Each pipe has a backpressure input. A picked wave issues only if its pipe is not backpressured. Every wave also receives a 4-bit code that says why it did or did not issue in that cycle. The per-pipe "picked" and "refused" bits for the whole SIMD are available live.

A sample strobe, together with a wave index, freezes a snapshot into registers. The snapshot holds:
- that wave's code,
- the per-pipe picked and refused bits,
- a flag for a two-VALU co-issue,
- the active-wave count of the whole compute unit.

The snapshot stays unchanged and flagged valid until the next strobe. Profiling logic can read it at leisure. Fetch, dependency tracking, memory counters and the pipes themselves are outside the block. They appear only as per-wave status inputs and per-pipe backpressure.

Top module: `waveIssueSampler`

## Requirements
- R1: After reset, `sampleValid`, `sampleReason`, `sampleIssue`, `sampleStall`, `sampleDual` and `sampleWaveCnt` are all zero.
- R2: An active wave with blocking flags is coded by the first flag set in this order:
  - no-instruction = 1
  - ALU dependency = 2
  - wait counter = 3
  - internal instruction = 4
  - barrier = 5
  - other = 6
- R3: An inactive wave is coded 15 and requests nothing, whatever its flags are.
- R4: A ready wave has no blocking flags. For each pipe, at most one ready wave targeting it is picked. The other ready waves on that pipe are coded 7 (lost arbitration).
- R5: A picked wave whose pipe is backpressured is coded 8 and does not assert `waveIssue`. A picked wave on a free pipe is coded 0 and asserts `waveIssue`.
- R6: Each pipe has a round-robin pointer. The pointer starts at wave 0 after reset. The pick is the first requester at or after the pointer, and the pointer moves to the winner plus one (wrapping) only in a cycle where the winner issues.
- R7: `pipeIssue[p]` is 1 when any wave was picked for pipe p. `pipeStall[p]` is 1 when pipe p refused its pick. The pipe numbering is:
  - 0 = vector ALU
  - 1 = matrix
  - 2 = local data share
  - 3 = scalar
  - 4 = texture/vector memory
  - 5 = flat memory
  - 6 = export
  - 7 = miscellaneous
- R8: A clock edge with `sampleStrobe` high registers the following and sets `sampleValid`:
  - the code of wave `sampleWave`,
  - `pipeIssue` and `pipeStall`,
  - `cuWaveCount`.
- R9: Without a strobe, every snapshot output holds its value.
- R10: `sampleDual` captures 1 only when `dualValu` is high and pipe 0 was picked and not refused in the strobe cycle.
- R11: Waves that target different pipes are picked and issued in the same cycle, independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| waveActive | input | NUM_WAVES | Wave slot holds a live wave |
| waveNoInst | input | NUM_WAVES | No instruction available |
| waveAluDep | input | NUM_WAVES | ALU dependency pending |
| waveWaitCnt | input | NUM_WAVES | Waiting on memory counter |
| waveInternal | input | NUM_WAVES | Internal instruction in progress |
| waveBarrier | input | NUM_WAVES | Waiting at barrier |
| waveOther | input | NUM_WAVES | Other blocking cause |
| wavePipe | input | 3*NUM_WAVES | Target pipe per wave, 3 bits each |
| pipeBackpressure | input | 8 | Pipe cannot accept this cycle |
| dualValu | input | 1 | Second VALU co-issue condition present |
| cuWaveCount | input | WCNT_W | Active waves across the compute unit |
| sampleStrobe | input | 1 | Capture a snapshot at this edge |
| sampleWave | input | WIDX_W | Wave to report in the snapshot |
| waveIssue | output | NUM_WAVES | Wave issued this cycle |
| waveReason | output | 4*NUM_WAVES | Per-wave code, 4 bits each |
| pipeIssue | output | 8 | Live per-pipe picked bits |
| pipeStall | output | 8 | Live per-pipe refused bits |
| sampleValid | output | 1 | Snapshot holds data |
| sampleReason | output | 4 | Captured wave code |
| sampleIssue | output | 8 | Captured picked bits |
| sampleStall | output | 8 | Captured refused bits |
| sampleDual | output | 1 | Captured two-VALU issue flag |
| sampleWaveCnt | output | WCNT_W | Captured compute-unit wave count |

## Verification
The round-robin pointers are the only hidden state apart from the snapshot. A pointer that moved when it should not have, or failed to move, shows up in the very next cycle in which two waves contend for that pipe: the wrong wave receives code 0 or 8. The bench therefore runs contention over several consecutive cycles, with and without backpressure, and checks each cycle's winner. A corrupted snapshot register appears one edge after the strobe, or as a change during the cycles without a strobe. The bench holds the inputs changing through such gaps.

// File: rtl/wis_pkg.sv
package wis_pkg;
  localparam int NUM_PIPES = 8;
  localparam int PIPE_W    = 3;
  localparam int REASON_W  = 4;

  localparam int PIPE_VALU = 0;

  typedef enum logic [REASON_W-1:0] {
    RS_ISSUED       = 4'd0,
    RS_NO_INST      = 4'd1,
    RS_ALU_DEP      = 4'd2,
    RS_WAIT_CNT     = 4'd3,
    RS_INTERNAL     = 4'd4,
    RS_BARRIER      = 4'd5,
    RS_OTHER        = 4'd6,
    RS_LOST_ARB     = 4'd7,
    RS_WON_BLOCKED  = 4'd8,
    RS_INACTIVE     = 4'd15
  } stall_reason_e;

  typedef struct packed {
    logic capture;
    logic markValid;
  } wis_ctrl_t;
endpackage

// File: rtl/wisPipeArb.sv
module wisPipeArb #(
  parameter int NUM_WAVES = 8,
  localparam int WIDX_W = $clog2(NUM_WAVES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_WAVES-1:0] req,
  input  logic                 backpressure,
  output logic [NUM_WAVES-1:0] grant
);
  logic [WIDX_W-1:0] ptr;
  logic [WIDX_W-1:0] winIdx;
  logic [WIDX_W-1:0] nextPtr;
  logic [WIDX_W:0]   probe;
  logic              found;

  // rotating-priority pick starting at the pointer
  always_comb begin
    grant  = '0;
    winIdx = '0;
    found  = 1'b0;
    probe  = '0;
    for (int k = 0; k < NUM_WAVES; k++) begin
      probe = {1'b0, ptr} + (WIDX_W+1)'(k);
      if (probe >= (WIDX_W+1)'(NUM_WAVES))
        probe = probe - (WIDX_W+1)'(NUM_WAVES);
      if (!found && req[probe[WIDX_W-1:0]]) begin
        found = 1'b1;
        winIdx = probe[WIDX_W-1:0];
        grant[probe[WIDX_W-1:0]] = 1'b1;
      end
    end
  end

  assign nextPtr = (winIdx == WIDX_W'(NUM_WAVES-1)) ? '0 : winIdx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN)
      ptr <= '0;
    else if (found && !backpressure)
      ptr <= nextPtr;
  end
endmodule

// File: rtl/wisControl.sv
module wisControl
  import wis_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleStrobe,
  output wis_ctrl_t ctrl,
  output logic      sampleValid
);
  always_comb begin
    ctrl.capture   = sampleStrobe;
    ctrl.markValid = sampleStrobe & ~sampleValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      sampleValid <= 1'b0;
    else if (ctrl.markValid)
      sampleValid <= 1'b1;
  end
endmodule

// File: rtl/wisDatapath.sv
module wisDatapath
  import wis_pkg::*;
#(
  parameter int NUM_WAVES = 8,
  parameter int WCNT_W    = 8,
  localparam int WIDX_W = $clog2(NUM_WAVES)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  wis_ctrl_t                     ctrl,
  input  logic [NUM_WAVES-1:0]          waveActive,
  input  logic [NUM_WAVES-1:0]          waveNoInst,
  input  logic [NUM_WAVES-1:0]          waveAluDep,
  input  logic [NUM_WAVES-1:0]          waveWaitCnt,
  input  logic [NUM_WAVES-1:0]          waveInternal,
  input  logic [NUM_WAVES-1:0]          waveBarrier,
  input  logic [NUM_WAVES-1:0]          waveOther,
  input  logic [PIPE_W*NUM_WAVES-1:0]   wavePipe,
  input  logic [NUM_PIPES-1:0]          pipeBackpressure,
  input  logic                          dualValu,
  input  logic [WCNT_W-1:0]             cuWaveCount,
  input  logic [WIDX_W-1:0]             sampleWave,
  output logic [NUM_WAVES-1:0]          waveIssue,
  output logic [REASON_W*NUM_WAVES-1:0] waveReason,
  output logic [NUM_PIPES-1:0]          pipeIssue,
  output logic [NUM_PIPES-1:0]          pipeStall,
  output logic [REASON_W-1:0]           sampleReason,
  output logic [NUM_PIPES-1:0]          sampleIssue,
  output logic [NUM_PIPES-1:0]          sampleStall,
  output logic                          sampleDual,
  output logic [WCNT_W-1:0]             sampleWaveCnt
);
  logic [NUM_WAVES-1:0] ready;
  logic [PIPE_W-1:0]    pipeOf [NUM_WAVES];
  logic [NUM_WAVES-1:0] req    [NUM_PIPES];
  logic [NUM_WAVES-1:0] grant  [NUM_PIPES];
  stall_reason_e        reasonArr [NUM_WAVES];

  assign ready = waveActive & ~(waveNoInst | waveAluDep | waveWaitCnt |
                                waveInternal | waveBarrier | waveOther);

  always_comb begin
    for (int w = 0; w < NUM_WAVES; w++)
      pipeOf[w] = wavePipe[w*PIPE_W +: PIPE_W];
  end

  always_comb begin
    for (int p = 0; p < NUM_PIPES; p++)
      for (int w = 0; w < NUM_WAVES; w++)
        req[p][w] = ready[w] && (pipeOf[w] == PIPE_W'(p));
  end

  for (genvar gp = 0; gp < NUM_PIPES; gp++) begin : g_arb
    wisPipeArb #(.NUM_WAVES(NUM_WAVES)) u_arb (
      .clk          (clk),
      .rstN         (rstN),
      .req          (req[gp]),
      .backpressure (pipeBackpressure[gp]),
      .grant        (grant[gp])
    );
  end

  always_comb begin
    for (int p = 0; p < NUM_PIPES; p++) begin
      pipeIssue[p] = |grant[p];
      pipeStall[p] = (|grant[p]) & pipeBackpressure[p];
    end
  end

  // per-wave code with fixed priority among blocking causes
  always_comb begin
    for (int w = 0; w < NUM_WAVES; w++) begin
      if (!waveActive[w])                  reasonArr[w] = RS_INACTIVE;
      else if (waveNoInst[w])              reasonArr[w] = RS_NO_INST;
      else if (waveAluDep[w])              reasonArr[w] = RS_ALU_DEP;
      else if (waveWaitCnt[w])             reasonArr[w] = RS_WAIT_CNT;
      else if (waveInternal[w])            reasonArr[w] = RS_INTERNAL;
      else if (waveBarrier[w])             reasonArr[w] = RS_BARRIER;
      else if (waveOther[w])               reasonArr[w] = RS_OTHER;
      else if (!grant[pipeOf[w]][w])       reasonArr[w] = RS_LOST_ARB;
      else if (pipeBackpressure[pipeOf[w]]) reasonArr[w] = RS_WON_BLOCKED;
      else                                 reasonArr[w] = RS_ISSUED;
      waveReason[w*REASON_W +: REASON_W] = reasonArr[w];
      waveIssue[w] = (reasonArr[w] == RS_ISSUED);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleReason  <= '0;
      sampleIssue   <= '0;
      sampleStall   <= '0;
      sampleDual    <= 1'b0;
      sampleWaveCnt <= '0;
    end else if (ctrl.capture) begin
      sampleReason  <= reasonArr[sampleWave];
      sampleIssue   <= pipeIssue;
      sampleStall   <= pipeStall;
      sampleDual    <= dualValu & pipeIssue[PIPE_VALU] & ~pipeStall[PIPE_VALU];
      sampleWaveCnt <= cuWaveCount;
    end
  end
endmodule

// File: rtl/waveIssueSampler.sv
module waveIssueSampler
  import wis_pkg::*;
#(
  parameter int NUM_WAVES = 8,
  parameter int WCNT_W    = 8,
  localparam int WIDX_W = $clog2(NUM_WAVES)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_WAVES-1:0]          waveActive,
  input  logic [NUM_WAVES-1:0]          waveNoInst,
  input  logic [NUM_WAVES-1:0]          waveAluDep,
  input  logic [NUM_WAVES-1:0]          waveWaitCnt,
  input  logic [NUM_WAVES-1:0]          waveInternal,
  input  logic [NUM_WAVES-1:0]          waveBarrier,
  input  logic [NUM_WAVES-1:0]          waveOther,
  input  logic [3*NUM_WAVES-1:0]        wavePipe,
  input  logic [7:0]                    pipeBackpressure,
  input  logic                          dualValu,
  input  logic [WCNT_W-1:0]             cuWaveCount,
  input  logic                          sampleStrobe,
  input  logic [WIDX_W-1:0]             sampleWave,
  output logic [NUM_WAVES-1:0]          waveIssue,
  output logic [4*NUM_WAVES-1:0]        waveReason,
  output logic [7:0]                    pipeIssue,
  output logic [7:0]                    pipeStall,
  output logic                          sampleValid,
  output logic [3:0]                    sampleReason,
  output logic [7:0]                    sampleIssue,
  output logic [7:0]                    sampleStall,
  output logic                          sampleDual,
  output logic [WCNT_W-1:0]             sampleWaveCnt
);
  wis_ctrl_t ctrl;

  wisControl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .sampleStrobe (sampleStrobe),
    .ctrl         (ctrl),
    .sampleValid  (sampleValid)
  );

  wisDatapath #(.NUM_WAVES(NUM_WAVES), .WCNT_W(WCNT_W)) u_dp (
    .clk              (clk),
    .rstN             (rstN),
    .ctrl             (ctrl),
    .waveActive       (waveActive),
    .waveNoInst       (waveNoInst),
    .waveAluDep       (waveAluDep),
    .waveWaitCnt      (waveWaitCnt),
    .waveInternal     (waveInternal),
    .waveBarrier      (waveBarrier),
    .waveOther        (waveOther),
    .wavePipe         (wavePipe),
    .pipeBackpressure (pipeBackpressure),
    .dualValu         (dualValu),
    .cuWaveCount      (cuWaveCount),
    .sampleWave       (sampleWave),
    .waveIssue        (waveIssue),
    .waveReason       (waveReason),
    .pipeIssue        (pipeIssue),
    .pipeStall        (pipeStall),
    .sampleReason     (sampleReason),
    .sampleIssue      (sampleIssue),
    .sampleStall      (sampleStall),
    .sampleDual       (sampleDual),
    .sampleWaveCnt    (sampleWaveCnt)
  );
endmodule

// File: rtl/wisChecker.sv
module wisChecker #(
  parameter int NUM_WAVES = 8,
  parameter int WCNT_W    = 8,
  localparam int WIDX_W = $clog2(NUM_WAVES)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NUM_WAVES-1:0]   waveActive,
  input logic [3*NUM_WAVES-1:0] wavePipe,
  input logic [7:0]             pipeBackpressure,
  input logic                   sampleStrobe,
  input logic [NUM_WAVES-1:0]   waveIssue,
  input logic [4*NUM_WAVES-1:0] waveReason,
  input logic [7:0]             pipeIssue,
  input logic [7:0]             pipeStall,
  input logic                   sampleValid,
  input logic [3:0]             sampleReason,
  input logic [7:0]             sampleIssue,
  input logic [7:0]             sampleStall,
  input logic                   sampleDual,
  input logic [WCNT_W-1:0]      sampleWaveCnt
);
  for (genvar gp = 0; gp < 8; gp++) begin : g_pipe
    logic [NUM_WAVES-1:0] issuedOn;
    logic [NUM_WAVES-1:0] pickedOn;
    always_comb begin
      for (int w = 0; w < NUM_WAVES; w++) begin
        issuedOn[w] = waveIssue[w] && (wavePipe[w*3 +: 3] == 3'(gp));
        pickedOn[w] = (wavePipe[w*3 +: 3] == 3'(gp)) &&
                      ((waveReason[w*4 +: 4] == 4'd0) || (waveReason[w*4 +: 4] == 4'd8));
      end
    end

    // R4
    one_winner_chk: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(pickedOn));

    // R5
    bp_no_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
      pipeBackpressure[gp] |-> (issuedOn == '0));

    // R7
    issue_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
      pipeIssue[gp] == (pickedOn != '0));
  end

  // R8
  valid_after_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |=> sampleValid);

  // R9
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStrobe |=> $stable({sampleValid, sampleReason, sampleIssue,
                               sampleStall, sampleDual, sampleWaveCnt}));

  // R3
  inactive_no_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (waveIssue & ~waveActive) == '0);
endmodule

bind waveIssueSampler wisChecker #(.NUM_WAVES(NUM_WAVES), .WCNT_W(WCNT_W)) u_chk (.*);

// File: tb/waveIssueSampler_bench.sv
module waveIssueSampler_bench;
  localparam int NW = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NW-1:0] act, noI, alu, wcn, itn, bar, oth;
  logic [3*NW-1:0] pipe;
  logic [7:0] bp;
  logic dual;
  logic [CW-1:0] cuCnt;
  logic strobe;
  logic [2:0] sWave;
  logic [NW-1:0] wIssue;
  logic [4*NW-1:0] wReason;
  logic [7:0] pIssue, pStall, sIssue, sStall;
  logic sValid, sDual;
  logic [3:0] sReason;
  logic [CW-1:0] sCnt;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  waveIssueSampler #(.NUM_WAVES(NW), .WCNT_W(CW)) u_waveIssueSampler (
    .clk(clk), .rstN(rstN), .waveActive(act), .waveNoInst(noI), .waveAluDep(alu),
    .waveWaitCnt(wcn), .waveInternal(itn), .waveBarrier(bar), .waveOther(oth),
    .wavePipe(pipe), .pipeBackpressure(bp), .dualValu(dual), .cuWaveCount(cuCnt),
    .sampleStrobe(strobe), .sampleWave(sWave), .waveIssue(wIssue), .waveReason(wReason),
    .pipeIssue(pIssue), .pipeStall(pStall), .sampleValid(sValid), .sampleReason(sReason),
    .sampleIssue(sIssue), .sampleStall(sStall), .sampleDual(sDual), .sampleWaveCnt(sCnt)
  );

  task automatic chk(input string req, input logic [31:0] actual, input logic [31:0] expected);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  function automatic logic [3:0] rsn(input int w);
    return wReason[w*4 +: 4];
  endfunction

  task automatic clearAll();
    act = '0; noI = '0; alu = '0; wcn = '0; itn = '0; bar = '0; oth = '0;
    pipe = '0; bp = '0; dual = 1'b0; cuCnt = '0; strobe = 1'b0; sWave = '0;
  endtask

  task automatic readyWave(input int w, input int p);
    act[w] = 1'b1;
    pipe[w*3 +: 3] = 3'(p);
  endtask

  task automatic doReset();
    @(negedge clk);
    clearAll();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 valid", 32'(sValid), 0);
    chk("R1 reason", 32'(sReason), 0);
    chk("R1 issue/stall", {16'd0, sIssue, sStall}, 0);
    chk("R1 dual/count", {23'd0, sDual, sCnt}, 0);
  endtask

  task automatic t_priority();
    doReset();
    act = 8'hFF;
    noI = 8'b0100_0001; alu = 8'b0100_0011; wcn = 8'b0000_0110;
    itn = 8'b0000_1100; bar = 8'b0001_1010; oth = 8'b0111_0100;
    act[6] = 1'b0;
    pipe[7*3 +: 3] = 3'd3;
    #1;
    chk("R2 noinst", 32'(rsn(0)), 1);
    chk("R2 aludep", 32'(rsn(1)), 2);
    chk("R2 waitcnt", 32'(rsn(2)), 3);
    chk("R2 internal", 32'(rsn(3)), 4);
    chk("R2 barrier", 32'(rsn(4)), 5);
    chk("R2 other", 32'(rsn(5)), 6);
    chk("R3 inactive", 32'(rsn(6)), 15);
    chk("R3 no request from blocked/inactive", 32'(pIssue), 32'h08);
    chk("R5 lone ready issues", 32'(rsn(7)), 0);
  endtask

  task automatic t_contend();
    doReset();
    readyWave(2, 1); readyWave(5, 1);
    #1;
    chk("R4 winner", 32'(rsn(2)), 0);
    chk("R4 loser", 32'(rsn(5)), 7);
    chk("R7 pipeIssue", 32'(pIssue), 32'h02);
    chk("R7 pipeStall", 32'(pStall), 0);
    chk("R5 waveIssue", 32'(wIssue), 32'h04);
  endtask

  task automatic t_roundrobin();
    int order[4] = '{1, 3, 6, 1};
    doReset();
    readyWave(1, 2); readyWave(3, 2); readyWave(6, 2);
    for (int c = 0; c < 4; c++) begin
      #1;
      chk("R6 rr winner", 32'(wIssue), 32'(1 << order[c]));
      @(negedge clk);
    end
  endtask

  task automatic t_backpressure();
    doReset();
    readyWave(0, 5); readyWave(4, 5);
    bp[5] = 1'b1;
    for (int c = 0; c < 2; c++) begin
      #1;
      chk("R5 blocked winner", 32'(rsn(0)), 8);
      chk("R5 loser", 32'(rsn(4)), 7);
      chk("R5 no issue", 32'(wIssue), 0);
      chk("R7 stall bit", {16'd0, pIssue, pStall}, 32'h2020);
      @(negedge clk);
    end
    bp[5] = 1'b0;
    #1;
    chk("R6 pointer held under backpressure", 32'(rsn(0)), 0);
    @(negedge clk);
    #1;
    chk("R6 pointer advanced after issue", 32'(rsn(4)), 0);
    chk("R6 previous winner loses", 32'(rsn(0)), 7);
  endtask

  task automatic t_parallel();
    doReset();
    for (int w = 0; w < NW; w++) readyWave(w, 7 - w);
    #1;
    chk("R11 all pipes issue", 32'(wIssue), 32'hFF);
    chk("R11 pipeIssue", 32'(pIssue), 32'hFF);
  endtask

  task automatic t_sample();
    doReset();
    readyWave(3, 0); readyWave(5, 0);
    cuCnt = 8'd37; dual = 1'b1; sWave = 3'd5; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    #1;
    chk("R8 valid", 32'(sValid), 1);
    chk("R8 reason", 32'(sReason), 7);
    chk("R8 bits", {16'd0, sIssue, sStall}, 32'h0100);
    chk("R10 dual on issued VALU", 32'(sDual), 1);
    chk("R8 count", 32'(sCnt), 37);
    act = '0; cuCnt = 8'd99; dual = 1'b0; bp = 8'hFF;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      #1;
      chk("R9 hold reason", 32'(sReason), 7);
      chk("R9 hold count", 32'(sCnt), 37);
      chk("R9 hold dual", 32'(sDual), 1);
    end
    readyWave(3, 0); readyWave(5, 0);
    dual = 1'b1; bp = 8'h01; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    #1;
    chk("R8 reason blocked winner", 32'(sReason), 8);
    chk("R10 dual suppressed by stall", 32'(sDual), 0);
    chk("R8 stall captured", {16'd0, sIssue, sStall}, 32'h0101);
    chk("R8 count recaptured", 32'(sCnt), 99);
  endtask

  initial begin
    clearAll();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_priority();
    t_contend();
    t_roundrobin();
    t_backpressure();
    t_parallel();
    t_sample();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule